// File: doc/BRIEF.md
# Supervisor Restore Mask and Header Validator

This block screens a privileged extended-state restore request before any state is read from memory. It is given an instruction mask, two enable bitmaps (one for user-managed state, one for supervisor-managed state), and the two 64-bit bitmaps from the save-area header. The first header bitmap gives the compacted layout: its top bit marks the compacted form, and its lower bits list the components present in the area. The second lists the components that hold saved data. The block also receives the rest of the header, the current privilege level and the low address bits of the save area.

The block forms the requested-feature set. From it, it splits the requested components into two sets: those to load from memory and those to reset to their initial values. It also raises one general-protection fault flag when any header or operand rule is broken. A request is made by pulsing `start_i`. The results are registered and appear with a one-cycle `done_o` pulse on the next clock edge. The outputs then hold until the next request.

Top module: `restore_hdr_validator`

## Requirements
- R1: `rfbm_o` equals `mask_i & (en_user_i | en_sup_i)` for the request sampled with `start_i`.
- R2: Let fmt be `comp_i` with bit 63 cleared. When there is no fault, `restore_o` equals `fmt & rfbm & present_i`.
- R3: When there is no fault, `init_o` equals `(rfbm & ~present_i) | (rfbm & ~fmt)`. Bit 63 is never part of fmt, so a requested bit 63 always lands in `init_o`.
- R4: `fault_o` is 1 when bit 63 of `comp_i` is 0.
- R5: `fault_o` is 1 when any bit in 62..0 of `comp_i` is 1 while the same bit of `en_user_i | en_sup_i` is 0.
- R6: `fault_o` is 1 when any bit of `present_i` is 1 while the same bit of `comp_i` is 0.
- R7: `fault_o` is 1 when any bit of `hdr_rest_i` (header bytes 16..63, byte 16 at bits 7:0) is nonzero.
- R8: `fault_o` is 1 when `addr_lo_i` (address bits 5:0) is nonzero or `priv_i` is nonzero.
- R9: When `fault_o` is 1, both `restore_o` and `init_o` are zero. `rfbm_o` is still reported.
- R10: `done_o` is 1 for exactly the one cycle after a clock edge that sampled `start_i` high. Between requests, all result outputs hold their values whatever the inputs do.
- R11: After reset, `done_o`, `fault_o`, `rfbm_o`, `restore_o` and `init_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe; inputs sampled on this edge |
| mask_i | input | 64 | Instruction mask |
| en_user_i | input | 64 | User state enable bitmap |
| en_sup_i | input | 64 | Supervisor state enable bitmap |
| comp_i | input | 64 | Header compaction bitmap; bit 63 marks the compacted form |
| present_i | input | 64 | Header state-present bitmap |
| hdr_rest_i | input | 384 | Header bytes 16..63 |
| priv_i | input | 2 | Current privilege level |
| addr_lo_i | input | 6 | Save-area address bits 5:0 |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | General-protection fault |
| rfbm_o | output | 64 | Requested-feature bitmap |
| restore_o | output | 64 | Components to load |
| init_o | output | 64 | Components to initialize |

## Verification
The assertions that compare results against `$past` inputs assume the inputs are steady across the edge that samples `start_i`. They also assume `start_i` is low during reset. The bench drives all inputs on the falling edge, so every sampling edge sees settled values.

Random requests are built so that the compaction bitmap is a subset of the enables and the present bitmap is a subset of the compaction bitmap. This makes the fault-free path common enough to check R2 and R3 well. A single fault condition is then injected on purpose in most of the remaining requests.

// File: rtl/rhv_pkg.sv
package rhv_pkg;
  localparam int MASK_W_DEF   = 64;
  localparam int HDR_BYTES_DEF = 48;
  localparam int ALIGN_W_DEF  = 6;
  localparam int PRIV_W_DEF   = 2;

  // fault cause slots
  localparam int FC_NOFMT   = 0;
  localparam int FC_COMP_EN = 1;
  localparam int FC_PRES    = 2;
  localparam int FC_HDR     = 3;
  localparam int FC_ALIGN   = 4;
  localparam int FC_PRIV    = 5;
  localparam int FC_COUNT   = 6;
endpackage

// File: rtl/rhv_mask_calc.sv
module rhv_mask_calc #(
  parameter int MASK_W = rhv_pkg::MASK_W_DEF
) (
  input  logic [MASK_W-1:0] mask_i,
  input  logic [MASK_W-1:0] en_user_i,
  input  logic [MASK_W-1:0] en_sup_i,
  input  logic [MASK_W-1:0] comp_i,
  input  logic [MASK_W-1:0] present_i,
  output logic [MASK_W-1:0] rfbm_o,
  output logic [MASK_W-1:0] restore_o,
  output logic [MASK_W-1:0] init_o
);
  localparam logic [MASK_W-1:0] FMT_KEEP = {1'b0, {(MASK_W-1){1'b1}}};

  logic [MASK_W-1:0] fmt;

  always_comb begin
    fmt       = comp_i & FMT_KEEP;
    rfbm_o    = mask_i & (en_user_i | en_sup_i);
    restore_o = fmt & rfbm_o & present_i;
    init_o    = (rfbm_o & ~present_i) | (rfbm_o & ~fmt);
  end
endmodule

// File: rtl/rhv_fault_check.sv
module rhv_fault_check #(
  parameter int MASK_W    = rhv_pkg::MASK_W_DEF,
  parameter int HDR_BYTES = rhv_pkg::HDR_BYTES_DEF,
  parameter int ALIGN_W   = rhv_pkg::ALIGN_W_DEF,
  parameter int PRIV_W    = rhv_pkg::PRIV_W_DEF
) (
  input  logic [MASK_W-1:0]      en_user_i,
  input  logic [MASK_W-1:0]      en_sup_i,
  input  logic [MASK_W-1:0]      comp_i,
  input  logic [MASK_W-1:0]      present_i,
  input  logic [HDR_BYTES*8-1:0] hdr_rest_i,
  input  logic [PRIV_W-1:0]      priv_i,
  input  logic [ALIGN_W-1:0]     addr_lo_i,
  output logic                   fault_o
);
  import rhv_pkg::*;

  logic [HDR_BYTES-1:0] byte_nz;
  logic [FC_COUNT-1:0]  cause;
  logic [MASK_W-2:0]    en_or_lo;

  for (genvar b = 0; b < HDR_BYTES; b++) begin : g_byte
    assign byte_nz[b] = |hdr_rest_i[b*8 +: 8];
  end

  always_comb begin
    en_or_lo           = en_user_i[MASK_W-2:0] | en_sup_i[MASK_W-2:0];
    cause              = '0;
    cause[FC_NOFMT]    = ~comp_i[MASK_W-1];
    cause[FC_COMP_EN]  = |(comp_i[MASK_W-2:0] & ~en_or_lo);
    cause[FC_PRES]     = |(present_i & ~comp_i);
    cause[FC_HDR]      = |byte_nz;
    cause[FC_ALIGN]    = |addr_lo_i;
    cause[FC_PRIV]     = |priv_i;
    fault_o            = |cause;
  end
endmodule

// File: rtl/restore_hdr_validator.sv
module restore_hdr_validator #(
  parameter int MASK_W    = rhv_pkg::MASK_W_DEF,
  parameter int HDR_BYTES = rhv_pkg::HDR_BYTES_DEF,
  parameter int ALIGN_W   = rhv_pkg::ALIGN_W_DEF,
  parameter int PRIV_W    = rhv_pkg::PRIV_W_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [MASK_W-1:0]      mask_i,
  input  logic [MASK_W-1:0]      en_user_i,
  input  logic [MASK_W-1:0]      en_sup_i,
  input  logic [MASK_W-1:0]      comp_i,
  input  logic [MASK_W-1:0]      present_i,
  input  logic [HDR_BYTES*8-1:0] hdr_rest_i,
  input  logic [PRIV_W-1:0]      priv_i,
  input  logic [ALIGN_W-1:0]     addr_lo_i,
  output logic                   done_o,
  output logic                   fault_o,
  output logic [MASK_W-1:0]      rfbm_o,
  output logic [MASK_W-1:0]      restore_o,
  output logic [MASK_W-1:0]      init_o
);
  logic [MASK_W-1:0] rfbm_c, restore_c, init_c;
  logic              fault_c;

  rhv_mask_calc #(.MASK_W(MASK_W)) u_mask (
    .mask_i   (mask_i),
    .en_user_i(en_user_i),
    .en_sup_i (en_sup_i),
    .comp_i   (comp_i),
    .present_i(present_i),
    .rfbm_o   (rfbm_c),
    .restore_o(restore_c),
    .init_o   (init_c)
  );

  rhv_fault_check #(
    .MASK_W(MASK_W), .HDR_BYTES(HDR_BYTES), .ALIGN_W(ALIGN_W), .PRIV_W(PRIV_W)
  ) u_fault (
    .en_user_i (en_user_i),
    .en_sup_i  (en_sup_i),
    .comp_i    (comp_i),
    .present_i (present_i),
    .hdr_rest_i(hdr_rest_i),
    .priv_i    (priv_i),
    .addr_lo_i (addr_lo_i),
    .fault_o   (fault_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      fault_o   <= 1'b0;
      rfbm_o    <= '0;
      restore_o <= '0;
      init_o    <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        fault_o   <= fault_c;
        rfbm_o    <= rfbm_c;
        // a faulting request loads and initializes nothing
        restore_o <= fault_c ? '0 : restore_c;
        init_o    <= fault_c ? '0 : init_c;
      end
    end
  end
endmodule

// File: rtl/rhv_checker.sv
module rhv_checker #(
  parameter int MASK_W = rhv_pkg::MASK_W_DEF,
  parameter int PRIV_W = rhv_pkg::PRIV_W_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [MASK_W-1:0] mask_i,
  input logic [MASK_W-1:0] en_user_i,
  input logic [MASK_W-1:0] en_sup_i,
  input logic              comp_top_i,
  input logic [PRIV_W-1:0] priv_i,
  input logic              done_o,
  input logic              fault_o,
  input logic [MASK_W-1:0] rfbm_o,
  input logic [MASK_W-1:0] restore_o,
  input logic [MASK_W-1:0] init_o
);
  assert_rfbm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rfbm_o == ($past(mask_i) & ($past(en_user_i) | $past(en_sup_i))));

  assert_restore_in_rfbm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_o & ~rfbm_o) == '0);

  assert_disjoint_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_o & init_o) == '0);

  assert_nofmt_fault_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(comp_top_i)) |-> fault_o);

  assert_priv_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(priv_i) != '0) |-> fault_o);

  assert_fault_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (restore_o == '0 && init_o == '0));

  assert_done_follows_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!done_o && $stable(rfbm_o) && $stable(fault_o)
                  && $stable(restore_o) && $stable(init_o)));
endmodule

bind restore_hdr_validator rhv_checker #(.MASK_W(MASK_W), .PRIV_W(PRIV_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mask_i    (mask_i),
  .en_user_i (en_user_i),
  .en_sup_i  (en_sup_i),
  .comp_top_i(comp_i[MASK_W-1]),
  .priv_i    (priv_i),
  .done_o    (done_o),
  .fault_o   (fault_o),
  .rfbm_o    (rfbm_o),
  .restore_o (restore_o),
  .init_o    (init_o)
);

// File: tb/restore_hdr_validator_tb.sv
module restore_hdr_validator_tb;
  localparam int MW = 64;
  localparam int HB = 48;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [MW-1:0] mask_i = '0, en_user_i = '0, en_sup_i = '0, comp_i = '0, present_i = '0;
  logic [HB*8-1:0] hdr_rest_i = '0;
  logic [1:0]    priv_i = '0;
  logic [5:0]    addr_lo_i = '0;
  logic          done_o, fault_o;
  logic [MW-1:0] rfbm_o, restore_o, init_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [MW-1:0] e_rfbm, e_rst, e_init;
  logic          e_flt;

  restore_hdr_validator u_dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model();
    logic [MW-1:0] fmt, en_or;
    logic f;
    en_or  = en_user_i | en_sup_i;
    fmt    = comp_i;
    fmt[63] = 1'b0;
    e_rfbm = mask_i & en_or;
    f = 1'b0;
    if (!comp_i[63]) f = 1'b1;                       // R4
    if ((fmt & ~en_or) != 0) f = 1'b1;               // R5
    if ((present_i & ~comp_i) != 0) f = 1'b1;        // R6
    if (hdr_rest_i != 0) f = 1'b1;                   // R7
    if (addr_lo_i != 0 || priv_i != 0) f = 1'b1;     // R8
    e_flt  = f;
    e_rst  = f ? '0 : (fmt & e_rfbm & present_i);                      // R2, R9
    e_init = f ? '0 : ((e_rfbm & ~present_i) | (e_rfbm & ~fmt));       // R3, R9
  endtask

  task automatic run(input string tag);
    @(negedge clk_i);
    start_i = 1'b1;
    model();
    @(negedge clk_i);
    start_i = 1'b0;
    check({"R10 done ", tag}, {63'd0, done_o}, 64'd1);
    check({"R1 rfbm ", tag}, rfbm_o, e_rfbm);
    check({"R4-8 fault ", tag}, {63'd0, fault_o}, {63'd0, e_flt});
    check({"R2 restore ", tag}, restore_o, e_rst);
    check({"R3 init ", tag}, init_o, e_init);
  endtask

  task automatic legal();
    logic [MW-1:0] en_or;
    en_user_i = r64() & r64();
    en_sup_i  = r64() & r64();
    en_or     = en_user_i | en_sup_i;
    comp_i    = (r64() & en_or) | (64'd1 << 63);
    present_i = r64() & comp_i;
    mask_i    = r64();
    hdr_rest_i = '0;
    priv_i    = '0;
    addr_lo_i = '0;
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11 done", {63'd0, done_o}, 64'd0);
    check("R11 fault", {63'd0, fault_o}, 64'd0);
    check("R11 rfbm", rfbm_o, '0);
    check("R11 restore", restore_o, '0);
    check("R11 init", init_o, '0);
    rst_ni = 1'b1;

    // minimal legal header: nothing present, everything requested initialized
    mask_i = '1; en_user_i = 64'h0000_0000_0000_00FF; en_sup_i = 64'h8000_0000_0000_FF00;
    comp_i = 64'h8000_0000_0000_0000; present_i = '0;
    run("R3 init-all");
    check("R3 bit63 init", {63'd0, init_o[63]}, 64'd1);

    // full restore of compacted components
    comp_i = 64'h8000_0000_0000_FFFF; present_i = 64'h0000_0000_0000_FFFF;
    run("R2 full");

    legal(); comp_i[63] = 1'b0; present_i = '0; run("R4 nofmt");
    legal(); en_user_i[5] = 1'b0; en_sup_i[5] = 1'b0; comp_i[5] = 1'b1; present_i[5] = 1'b0;
    run("R5 comp-not-enabled");
    legal(); comp_i[9] = 1'b0; present_i[9] = 1'b1; run("R6 present-not-comp");
    legal(); hdr_rest_i[HB*8-1] = 1'b1; run("R7 hdr-last");
    legal(); hdr_rest_i[0] = 1'b1; run("R7 hdr-first");
    legal(); addr_lo_i = 6'd32; run("R8 align");
    legal(); priv_i = 2'd3; run("R8 priv");
    check("R9 fault seen", {63'd0, fault_o}, 64'd1);

    // R10 hold: inputs change without start
    legal(); run("R10 base");
    begin
      logic [MW-1:0] h_r, h_s, h_i; logic h_f;
      h_r = rfbm_o; h_s = restore_o; h_i = init_o; h_f = fault_o;
      mask_i = ~mask_i; comp_i = '0; priv_i = 2'd1;
      @(negedge clk_i);
      check("R10 done low", {63'd0, done_o}, 64'd0);
      @(negedge clk_i);
      check("R10 hold rfbm", rfbm_o, h_r);
      check("R10 hold restore", restore_o, h_s);
      check("R10 hold init", init_o, h_i);
      check("R10 hold fault", {63'd0, fault_o}, {63'd0, h_f});
    end

    for (int k = 0; k < 400; k++) begin
      int sel, bi;
      legal();
      sel = $urandom_range(0, 8);
      bi  = $urandom_range(0, 62);
      case (sel)
        0: comp_i[63] = 1'b0;
        1: begin en_user_i[bi] = 1'b0; en_sup_i[bi] = 1'b0; comp_i[bi] = 1'b1; end
        2: begin comp_i[bi] = 1'b0; present_i[bi] = 1'b1; end
        3: hdr_rest_i[$urandom_range(0, HB*8-1)] = 1'b1;
        4: addr_lo_i = 6'($urandom_range(1, 63));
        5: priv_i = 2'($urandom_range(1, 3));
        default: ;
      endcase
      run("rand");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule